// File: doc/BRIEF.md
# Conversion Start and Power-Down Sequencer

This block runs each conversion of a successive-approximation converter. A conversion can begin in two ways. The first is a falling edge on the external start pin that stays low for a minimum width. The second is a one-cycle software start request. The block then puts the track/hold into hold, pulses a start strobe to the converter core and counts a fixed conversion window in system clock cycles. On the last cycle of the window it pulses done and raises a result-valid flag. That flag stays set until the serial port begins a read.

When a conversion ends, the block samples the synchronized start-pin level. A high pin keeps the converter powered for high-throughput operation. A low pin sends it into automatic power-down. A software power-down request also forces power-down, and it can be applied either at the end of a conversion or while the block is idle. Power-down comes in two kinds: full, or partial with the reference kept on. A rising edge on the pin, or a software start, wakes the block. It then waits a fixed power-up window before a new conversion may begin. Start requests that arrive while the block is converting or powering up are dropped and recorded in a sticky overrun flag.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, ready_o=1, powered_o=1, ref_on_o=1, and hold_o, core_start_o, done_o, result_valid_o and overrun_o are all 0.
- R2: A start-pin falling edge, seen through the SYNC_STAGES synchronizer, whose low level lasts at least MIN_PULSE cycles starts a conversion when ready_o=1. hold_o goes high, and core_start_o is high for exactly the first cycle of hold_o.
- R3: A one-cycle sw_start_i pulse while ready_o=1 starts a conversion, in the same way as R2.
- R4: hold_o stays high for exactly CONV_CYC cycles. done_o is high only in the last of those cycles.
- R5: result_valid_o rises in the cycle after done_o and falls in the cycle after read_start_i. If both happen in the same cycle, the set wins.
- R6: When a conversion ends, the block returns to ready if the synchronized pin is high and sw_pd_i=0. Otherwise it enters power-down.
- R7: In power-down, powered_o=0 and ref_on_o equals pd_partial_i (1 = partial, reference on). Outside power-down, both outputs are 1.
- R8: In power-down with sw_pd_i=0, a pin rising edge or a sw_start_i pulse begins a power-up window. During that window powered_o=1 and ready_o=0 for exactly PWRUP_CYC cycles, after which ready_o=1. While sw_pd_i=1, the block stays powered down.
- R9: sw_pd_i=1 while ready, with no start request, puts the block into power-down on the next cycle. A start request in the same cycle takes priority.
- R10: A start request during a conversion or a power-up window is ignored and sets overrun_o. overrun_o stays set until reset, and the conversion in progress keeps its length.
- R11: A low pulse on the start pin shorter than MIN_PULSE cycles starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_pin_i | input | 1 | External convert-start pin (asynchronous) |
| sw_start_i | input | 1 | Software convert-start request, one cycle |
| sw_pd_i | input | 1 | Software power-down request, level |
| pd_partial_i | input | 1 | Power-down kind: 1 partial (reference kept), 0 full |
| read_start_i | input | 1 | Serial port read start; clears result valid |
| hold_o | output | 1 | Track/hold in hold, conversion running |
| core_start_o | output | 1 | One-cycle start strobe to the converter core |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| result_valid_o | output | 1 | Unread result available |
| ready_o | output | 1 | Powered and idle, can accept a start |
| powered_o | output | 1 | Converter core supply enable |
| ref_on_o | output | 1 | Internal reference enable |
| overrun_o | output | 1 | Sticky: a start request was dropped |

## Verification
Some properties are checked on every cycle: the strobe ordering, the length of the conversion window (measured by a counter in the checker), the single-cycle done pulse, the setting of result-valid after done, the reference staying on whenever the core is powered, entry into power-up before ready, and the stickiness of overrun. Other behaviour only the bench scenarios can show, because it depends on the input history: whether the end-of-conversion decision follows the pin level and the power-down request, the exact length of the power-up window, that narrow pulses are rejected, that start wins over power-down, and that wakes are blocked while power-down is held.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_PWRUP = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cseq_pin_qual.sv
module cseq_pin_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_PULSE   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic fall_ok_o,
  output logic rise_o
);
  localparam int unsigned LW = $clog2(MIN_PULSE + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q, armed_q;
  logic [LW-1:0]          low_cnt_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= pin_i;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  endgenerate

  assign lvl_o     = sync_q[SYNC_STAGES-1];
  assign rise_o    = lvl_o && !prev_q;
  // qualified edge fires once the low level reaches the minimum width
  assign fall_ok_o = armed_q && !lvl_o && (low_cnt_q == LW'(MIN_PULSE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= 1'b1;
      armed_q   <= 1'b0;
      low_cnt_q <= '0;
    end else begin
      prev_q <= lvl_o;
      if (lvl_o) begin
        armed_q   <= 1'b1;
        low_cnt_q <= '0;
      end else if (armed_q) begin
        if (fall_ok_o) begin
          armed_q   <= 1'b0;
          low_cnt_q <= '0;
        end else begin
          low_cnt_q <= low_cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cseq_timer.sv
module cseq_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (!zero_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/cseq_flags.sv
module cseq_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic read_i,
  input  logic overrun_set_i,
  output logic result_valid_o,
  output logic overrun_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_valid_o <= 1'b0;
      overrun_o      <= 1'b0;
    end else begin
      if (done_i)      result_valid_o <= 1'b1;
      else if (read_i) result_valid_o <= 1'b0;
      if (overrun_set_i) overrun_o <= 1'b1;
    end
  end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import cseq_pkg::*;
#(
  parameter int unsigned CONV_CYC    = 230,
  parameter int unsigned PWRUP_CYC   = 150,
  parameter int unsigned MIN_PULSE   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_pin_i,
  input  logic sw_start_i,
  input  logic sw_pd_i,
  input  logic pd_partial_i,
  input  logic read_start_i,
  output logic hold_o,
  output logic core_start_o,
  output logic done_o,
  output logic result_valid_o,
  output logic ready_o,
  output logic powered_o,
  output logic ref_on_o,
  output logic overrun_o
);
  localparam int unsigned MAX_CYC = (CONV_CYC > PWRUP_CYC) ? CONV_CYC : PWRUP_CYC;
  localparam int unsigned TW      = $clog2(MAX_CYC + 1);

  seq_state_e    state_q, state_d;
  logic          pin_lvl, pin_fall, pin_rise;
  logic          start_req, tmr_zero, tmr_load;
  logic [TW-1:0] tmr_val;
  logic          core_start_q;

  cseq_pin_qual #(.SYNC_STAGES(SYNC_STAGES), .MIN_PULSE(MIN_PULSE)) u_pin (
    .clk_i, .rst_ni, .pin_i(start_pin_i),
    .lvl_o(pin_lvl), .fall_ok_o(pin_fall), .rise_o(pin_rise)
  );

  cseq_timer #(.TW(TW)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  assign start_req = pin_fall || sw_start_i;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = TW'(CONV_CYC - 1);
    unique case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          state_d  = ST_CONV;
          tmr_load = 1'b1;
        end else if (sw_pd_i) begin
          state_d = ST_SLEEP;
        end
      end
      ST_CONV: begin
        if (tmr_zero) state_d = (pin_lvl && !sw_pd_i) ? ST_IDLE : ST_SLEEP;
      end
      ST_SLEEP: begin
        if ((pin_rise || sw_start_i) && !sw_pd_i) begin
          state_d  = ST_PWRUP;
          tmr_load = 1'b1;
          tmr_val  = TW'(PWRUP_CYC - 1);
        end
      end
      ST_PWRUP: begin
        if (tmr_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      core_start_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      core_start_q <= (state_q == ST_IDLE) && start_req;
    end
  end

  cseq_flags u_flags (
    .clk_i, .rst_ni,
    .done_i(done_o),
    .read_i(read_start_i),
    .overrun_set_i(start_req && ((state_q == ST_CONV) || (state_q == ST_PWRUP))),
    .result_valid_o,
    .overrun_o
  );

  assign hold_o       = (state_q == ST_CONV);
  assign core_start_o = core_start_q;
  assign done_o       = (state_q == ST_CONV) && tmr_zero;
  assign ready_o      = (state_q == ST_IDLE);
  assign powered_o    = (state_q != ST_SLEEP);
  assign ref_on_o     = powered_o || pd_partial_i;
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int unsigned CONV_CYC = 230
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hold_o,
  input logic core_start_o,
  input logic done_o,
  input logic result_valid_o,
  input logic ready_o,
  input logic powered_o,
  input logic ref_on_o,
  input logic overrun_o
);
  int unsigned hold_run;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) hold_run <= 0;
    else         hold_run <= hold_o ? hold_run + 1 : 0;

  a_r2_start_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |-> hold_o);
  a_r2_start_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |=> !core_start_o);
  a_r4_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r4_conv_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (hold_o && hold_run == CONV_CYC - 1));
  a_r5_valid_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> result_valid_o);
  a_r7_ref_when_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    powered_o |-> ref_on_o);
  a_r7_sleep_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !powered_o |-> (!ready_o && !hold_o));
  a_r8_wake_via_pwrup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(powered_o) |-> !ready_o);
  a_r10_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

bind conv_sequencer conv_sequencer_chk #(.CONV_CYC(CONV_CYC)) u_chk (
  .clk_i, .rst_ni, .hold_o, .core_start_o, .done_o, .result_valid_o,
  .ready_o, .powered_o, .ref_on_o, .overrun_o
);

// File: tb/conv_sequencer_tb_top.sv
module conv_sequencer_tb_top;
  localparam int CONV  = 12;
  localparam int PWRUP = 8;
  localparam int MINP  = 3;

  logic clk_i = 0, rst_ni = 0;
  logic start_pin_i = 1, sw_start_i = 0, sw_pd_i = 0, pd_partial_i = 0, read_start_i = 0;
  logic hold_o, core_start_o, done_o, result_valid_o, ready_o, powered_o, ref_on_o, overrun_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  conv_sequencer #(.CONV_CYC(CONV), .PWRUP_CYC(PWRUP), .MIN_PULSE(MINP), .SYNC_STAGES(2)) dut_i (
    .clk_i, .rst_ni, .start_pin_i, .sw_start_i, .sw_pd_i, .pd_partial_i, .read_start_i,
    .hold_o, .core_start_o, .done_o, .result_valid_o, .ready_o, .powered_o, .ref_on_o, .overrun_o
  );

  // {keep pin low, sw power-down, partial, expected powered, expected ref_on}
  localparam logic [4:0] VEC [0:5] = '{
    5'b0_0_0_1_1, 5'b1_0_0_0_0, 5'b1_0_1_0_1,
    5'b0_1_0_0_0, 5'b0_1_1_0_1, 5'b1_1_1_0_1
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; start_pin_i = 1; sw_start_i = 0; sw_pd_i = 0; pd_partial_i = 0; read_start_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic pulse_sw_start();
    sw_start_i = 1; @(negedge clk_i); sw_start_i = 0;
  endtask

  task automatic wait_hold(output bit seen, input int lim);
    seen = 0;
    for (int t = 0; t < lim; t++) begin
      if (hold_o) begin seen = 1; break; end
      @(negedge clk_i);
    end
  endtask

  task automatic count_conv(output int len, output int dn, output int cs);
    len = 0; dn = 0; cs = 0;
    while (hold_o && len < 100) begin
      len++;
      if (done_o) dn++;
      if (core_start_o) cs++;
      @(negedge clk_i);
    end
  endtask

  task automatic wait_ready();
    for (int t = 0; t < 60 && !ready_o; t++) @(negedge clk_i);
  endtask

  initial begin
    bit seen;
    int len, dn, cs, pw;
    do_reset();

    // R1 reset state
    chk(ready_o && powered_o && ref_on_o, "R1 ready/powered/ref", {ready_o, powered_o, ref_on_o}, 7);
    chk(!hold_o && !core_start_o && !done_o && !result_valid_o && !overrun_o, "R1 quiet outputs",
        {hold_o, core_start_o, done_o, result_valid_o, overrun_o}, 0);

    // R6 R7 end-of-conversion decision vectors
    foreach (VEC[i]) begin
      pd_partial_i = VEC[i][2];
      start_pin_i = 0;
      if (!VEC[i][4]) begin
        repeat (MINP + 1) @(negedge clk_i);
        start_pin_i = 1;
      end
      wait_hold(seen, 40);
      chk(seen, "R2 pin start", seen, 1);
      chk(ref_on_o && powered_o, "R7 awake during conv", ref_on_o, 1);
      sw_pd_i = VEC[i][3];
      count_conv(len, dn, cs);
      chk(len == CONV, "R4 conv length", len, CONV);
      chk(dn == 1 && cs == 1, "R4 done/R2 strobe count", dn * 10 + cs, 11);
      chk(result_valid_o, "R5 valid after done", result_valid_o, 1);
      chk(powered_o == VEC[i][1], "R6 powered after end", powered_o, VEC[i][1]);
      chk(ref_on_o == VEC[i][0], "R7 ref after end", ref_on_o, VEC[i][0]);
      chk(ready_o == VEC[i][1], "R6 ready after end", ready_o, VEC[i][1]);
      read_start_i = 1; @(negedge clk_i); read_start_i = 0;
      chk(!result_valid_o, "R5 read clears", result_valid_o, 0);
      if (!powered_o) begin
        sw_pd_i = 0;
        if (!start_pin_i) begin start_pin_i = 1; @(negedge clk_i); end
        else pulse_sw_start();
      end
      sw_pd_i = 0; pd_partial_i = 0;
      wait_ready();
      chk(ready_o, "R8 back to ready", ready_o, 1);
      repeat (3) @(negedge clk_i);
    end

    // R11 narrow pulse ignored
    start_pin_i = 0; repeat (MINP - 1) @(negedge clk_i); start_pin_i = 1;
    wait_hold(seen, 20);
    chk(!seen && ready_o, "R11 narrow pulse ignored", seen, 0);

    // R3 software start; R5 set wins over simultaneous read
    pulse_sw_start();
    read_start_i = 1;
    wait_hold(seen, 5);
    chk(seen, "R3 sw start", seen, 1);
    count_conv(len, dn, cs);
    read_start_i = 0;
    chk(len == CONV && cs == 1, "R3 sw conv length", len, CONV);
    chk(result_valid_o, "R5 set wins", result_valid_o, 1);
    chk(!overrun_o, "R10 no overrun yet", overrun_o, 0);

    // R10 start during conversion
    pulse_sw_start();
    repeat (3) @(negedge clk_i);
    pulse_sw_start();
    count_conv(len, dn, cs);
    chk(len == CONV - 4 && dn == 1, "R10 conv keeps length", len, CONV - 4);
    chk(overrun_o, "R10 overrun set", overrun_o, 1);
    repeat (5) @(negedge clk_i);
    chk(overrun_o, "R10 overrun sticky", overrun_o, 1);
    do_reset();
    chk(!overrun_o, "R1 reset clears overrun", overrun_o, 0);

    // R9 sw power-down in idle; R8 blocked wake
    sw_pd_i = 1; @(negedge clk_i);
    chk(!powered_o && !ref_on_o, "R9 idle power-down", powered_o, 0);
    pulse_sw_start();
    repeat (10) @(negedge clk_i);
    chk(!powered_o, "R8 wake blocked by sw_pd", powered_o, 0);
    sw_pd_i = 0;
    pulse_sw_start();
    pw = 0;
    while (powered_o && !ready_o && pw < 50) begin pw++; @(negedge clk_i); end
    chk(pw == PWRUP, "R8 power-up window", pw, PWRUP);
    // R10 start during power-up
    sw_pd_i = 1; @(negedge clk_i); sw_pd_i = 0;
    start_pin_i = 0; @(negedge clk_i); start_pin_i = 1;
    repeat (4) @(negedge clk_i);
    pulse_sw_start();
    wait_ready();
    wait_hold(seen, 15);
    chk(!seen && overrun_o, "R10 start during power-up dropped", seen, 0);

    // R9 start wins over sw_pd in the same cycle
    sw_pd_i = 1; sw_start_i = 1; @(negedge clk_i); sw_start_i = 0;
    chk(hold_o && powered_o, "R9 start wins", hold_o, 1);
    count_conv(len, dn, cs);
    chk(!powered_o, "R6 sw_pd at end sleeps", powered_o, 0);
    sw_pd_i = 0;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule